// File: doc/BRIEF.md
# Binary Motion Label Relaxation Unit

This block makes one iterated-conditional-mode decision for one pixel of a binary motion map on every clock. The surrounding logic gathers, for each pixel, how many of its eight spatial neighbours in the current label frame are marked as moving, the label at the same position in the previous and the next frame, and the pixel's observation value. It also supplies the per-frame foreground amplitude and a scale factor derived from the frame's observation variance. The block returns the new label for that pixel.

The decision has no data-dependent branches. A weighted ten-site neighbourhood energy is computed in closed form from the three counts. It is then compared with a fitness-difference threshold built from the observation, the amplitude and the scale. The label is set to 1 only when the neighbourhood energy of the moving state is strictly below that threshold. The label the pixel held before is not an input, so it has no influence on the result. Several full scans of a frame, typically four, are run through the unit to approximate relaxation.

The unit is a three-stage pipeline with a valid/ready handshake on both sides. With no backpressure it accepts one pixel per cycle.

Top module: `icm_label_unit`

## Requirements
- R1: Label code 1 means moving and 0 means static. The moving-state model energy is um1 = (8 − 2·s)·20 + (1 − 2·p)·10 + (1 − 2·f)·30, where s is the spatial neighbour count, p is the past label and f is the future label. Each weight is a parameter.
- R2: out_label is 1 exactly when um1·2^16 < a·(2·o − a)·k, where a is in_amp, o is in_obs and k is in_scale. On equality the label is 0.
- R3: An in_nbr_cnt value above 8 is treated as 8.
- R4: in_scale is an unsigned fixed-point value with 16 fractional bits (18 bits wide by default, so 65536 means 1.0). With in_scale = 0 the label is 1 exactly when um1 < 0.
- R5: While out_ready stays high, a pixel accepted at a clock edge appears with out_valid high after the third clock edge, and one pixel is accepted every cycle.
- R6: After reset, out_valid is low and in_ready is high.
- R7: While out_valid is high and out_ready is low, in_ready is low, and out_valid and out_label hold their values into the next cycle.
- R8: Observation 0 and both extreme neighbour counts (0 and 8) give the label that R2 requires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pixel operands present |
| in_ready | output | 1 | Unit accepts a pixel at this edge |
| in_nbr_cnt | input | 4 | Moving spatial neighbours, saturated at 8 |
| in_past | input | 1 | Co-located label, previous frame |
| in_fut | input | 1 | Co-located label, next frame |
| in_obs | input | 8 | Unsigned observation value |
| in_amp | input | 8 | Foreground amplitude for the frame |
| in_scale | input | 18 | Variance-derived scale, 16 fractional bits |
| out_valid | output | 1 | New label present |
| out_ready | input | 1 | Downstream takes the label |
| out_label | output | 1 | New motion label |

## Verification
If an energy weight or the sign handling of the threshold product is wrong, the error appears as a wrong out_label exactly three edges after the affected pixel enters. Threshold ties and the extreme neighbour counts show such an error first. A wrong valid shift or stall decision shows at once as a label out of order, a lost pixel or a duplicated pixel, or as a latency other than three. The reference queue catches each of these on the cycle where the label is handed over. A label that changes while the output is held shows in the cycle right after the stall.

// File: rtl/icm_pkg.sv
package icm_pkg;
  // Saturate a neighbour count to the number of spatial sites.
  function automatic int clamp_count(input int cnt, input int lim);
    return (cnt > lim) ? lim : cnt;
  endfunction

  // Signed contribution of one weighted site group:
  // (sites - 2*ones) * weight.
  function automatic int site_energy(input int sites, input int ones, input int weight);
    return (sites - 2 * ones) * weight;
  endfunction
endpackage

// File: rtl/icm_model_energy.sv
module icm_model_energy
  import icm_pkg::*;
#(
  parameter int NSP    = 8,
  parameter int W_SP   = 20,
  parameter int W_PAST = 10,
  parameter int W_FUT  = 30,
  parameter int CNT_W  = 4,
  parameter int EW     = 12
) (
  input  logic [CNT_W-1:0]     nbr_cnt,
  input  logic                 past_lbl,
  input  logic                 fut_lbl,
  output logic signed [EW-1:0] um1
);
  int cnt_sat;
  int e_sum;

  always_comb begin
    cnt_sat = clamp_count(int'(nbr_cnt), NSP);
    e_sum   = site_energy(NSP, cnt_sat, W_SP)
            + site_energy(1, int'(past_lbl), W_PAST)
            + site_energy(1, int'(fut_lbl), W_FUT);
  end

  assign um1 = EW'(e_sum);
endmodule

// File: rtl/icm_fitness_gain.sv
module icm_fitness_gain #(
  parameter int AW = 8,
  parameter int OW = 8,
  parameter int GW = AW + OW + 3
) (
  input  logic [AW-1:0]        amp,
  input  logic [OW-1:0]        obs,
  output logic signed [GW-1:0] gain
);
  logic signed [GW-1:0] amp_x;
  logic signed [GW-1:0] obs_x;
  logic signed [GW-1:0] diff;

  assign amp_x = GW'({1'b0, amp});
  assign obs_x = GW'({1'b0, obs});
  assign diff  = (obs_x <<< 1) - amp_x;
  assign gain  = amp_x * diff;
endmodule

// File: rtl/icm_valid_pipe.sv
module icm_valid_pipe #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  input  logic in_v,
  output logic out_v
);
  logic [DEPTH-1:0] vld_q;

  generate
    if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst)      vld_q <= '0;
        else if (adv) vld_q <= in_v;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst)      vld_q <= '0;
        else if (adv) vld_q <= {vld_q[DEPTH-2:0], in_v};
      end
    end
  endgenerate

  assign out_v = vld_q[DEPTH-1];
endmodule

// File: rtl/icm_label_unit.sv
module icm_label_unit #(
  parameter int NSP    = 8,
  parameter int W_SP   = 20,
  parameter int W_PAST = 10,
  parameter int W_FUT  = 30,
  parameter int AW     = 8,
  parameter int OW     = 8,
  parameter int KW     = 18,
  parameter int FRAC   = 16,
  parameter int EW     = 12,
  localparam int CNT_W = $clog2(NSP + 1),
  localparam int GW    = AW + OW + 3,
  localparam int CW    = GW + KW + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CNT_W-1:0] in_nbr_cnt,
  input  logic             in_past,
  input  logic             in_fut,
  input  logic [OW-1:0]    in_obs,
  input  logic [AW-1:0]    in_amp,
  input  logic [KW-1:0]    in_scale,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_label
);
  localparam int DEPTH = 3;

  logic advance;
  logic signed [EW-1:0] um1_d, um1_q;
  logic signed [GW-1:0] gain_d, gain_q;
  logic [KW-1:0]        scale_q;
  logic signed [CW-1:0] gain_x, scale_x, lhs_d, rhs_d, lhs_q, rhs_q;
  logic                 label_q;

  // Whole pipe moves when the output slot is free or drained.
  assign advance  = out_ready || !out_valid;
  assign in_ready = advance;

  icm_model_energy #(
    .NSP(NSP), .W_SP(W_SP), .W_PAST(W_PAST), .W_FUT(W_FUT),
    .CNT_W(CNT_W), .EW(EW)
  ) u_model (
    .nbr_cnt (in_nbr_cnt),
    .past_lbl(in_past),
    .fut_lbl (in_fut),
    .um1     (um1_d)
  );

  icm_fitness_gain #(.AW(AW), .OW(OW), .GW(GW)) u_fit (
    .amp (in_amp),
    .obs (in_obs),
    .gain(gain_d)
  );

  icm_valid_pipe #(.DEPTH(DEPTH)) u_vld (
    .clk  (clk),
    .rst  (rst),
    .adv  (advance),
    .in_v (in_valid),
    .out_v(out_valid)
  );

  // Stage 1: energies from raw operands.
  always_ff @(posedge clk) begin
    if (advance) begin
      um1_q   <= um1_d;
      gain_q  <= gain_d;
      scale_q <= in_scale;
    end
  end

  // Stage 2: align model energy to the threshold's fixed point.
  assign gain_x  = CW'(gain_q);
  assign scale_x = CW'({1'b0, scale_q});
  assign rhs_d   = gain_x * scale_x;
  assign lhs_d   = CW'(um1_q) <<< FRAC;

  always_ff @(posedge clk) begin
    if (advance) begin
      lhs_q <= lhs_d;
      rhs_q <= rhs_d;
    end
  end

  // Stage 3: strict comparison, tie resolves to static.
  always_ff @(posedge clk) begin
    if (advance) label_q <= (lhs_q < rhs_q);
  end

  assign out_label = label_q;
endmodule

// File: rtl/icm_label_unit_chk.sv
module icm_label_unit_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_label
);
  logic [1:0] age_q;
  logic       acc;

  always_ff @(posedge clk) begin
    if (rst)                 age_q <= 2'd0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  assign acc = in_valid && in_ready && !rst;

  // R6: output empty right after reset
  p_idle_after_reset_r6: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

  // R7: stall blocks input
  p_stall_blocks_input_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R7: stalled result held
  p_stall_holds_label_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_label)));

  // R5: three-edge latency without backpressure
  p_latency_three_r5: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd3 && $past(acc, 3) && $past(out_ready, 2) && $past(out_ready, 1)
     && !$past(rst, 2) && !$past(rst, 1)) |-> out_valid);

  // R2: presented label is a known value
  p_label_known_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$isunknown(out_label));
endmodule

bind icm_label_unit icm_label_unit_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_label(out_label)
);

// File: tb/tb_icm_label_unit.sv
module tb_icm_label_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_ready, in_past, in_fut;
  logic [3:0]  in_nbr_cnt;
  logic [7:0]  in_obs, in_amp;
  logic [17:0] in_scale;
  logic        out_valid, out_ready, out_label;

  always #5 clk = ~clk;

  icm_label_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_nbr_cnt(in_nbr_cnt), .in_past(in_past), .in_fut(in_fut),
    .in_obs(in_obs), .in_amp(in_amp), .in_scale(in_scale),
    .out_valid(out_valid), .out_ready(out_ready), .out_label(out_label)
  );

  typedef struct {
    bit    lbl;
    int    cyc;
    string tag;
  } exp_t;

  exp_t  q[$];
  int    n_chk = 0;
  int    n_fail = 0;
  int    cyc = 0;
  bit    hold_pend = 0;
  bit    hold_lbl = 0;
  bit    done = 0;
  string cur_tag = "R2";

  function automatic bit ref_label(int s, int p, int f, int a, int o, int k);
    int      sc;
    longint  um, lhs, rhs;
    sc  = (s > 8) ? 8 : s;
    um  = 200 - 40 * sc - 20 * p - 60 * f;
    lhs = um * 65536;
    rhs = longint'(a) * longint'(2 * o - a) * longint'(k);
    return lhs < rhs;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic tick(input bit chk_lat);
    exp_t e;
    #1;
    if (hold_pend) begin
      check(out_valid === 1'b1, "R7", int'(out_valid), 1);
      check(out_label === hold_lbl, "R7", int'(out_label), int'(hold_lbl));
    end
    if (out_valid && out_ready) begin
      if (q.size() == 0) begin
        check(1'b0, "R5", 1, 0);
      end else begin
        e = q.pop_front();
        check(out_label === e.lbl, e.tag, int'(out_label), int'(e.lbl));
        if (chk_lat) check(cyc - e.cyc == 3, "R5", cyc - e.cyc, 3);
      end
    end
    if (out_valid && !out_ready) begin
      check(in_ready === 1'b0, "R7", int'(in_ready), 0);
      hold_pend = 1;
      hold_lbl  = out_label;
    end else begin
      hold_pend = 0;
    end
    if (in_valid && in_ready) begin
      e.lbl = ref_label(int'(in_nbr_cnt), int'(in_past), int'(in_fut),
                        int'(in_amp), int'(in_obs), int'(in_scale));
      e.cyc = cyc;
      e.tag = cur_tag;
      q.push_back(e);
    end
    @(negedge clk);
    cyc++;
  endtask

  task automatic send(input int s, input int p, input int f, input int o,
                      input int a, input int k, input string tag);
    in_valid   = 1'b1;
    in_nbr_cnt = 4'(s);
    in_past    = p[0];
    in_fut     = f[0];
    in_obs     = 8'(o);
    in_amp     = 8'(a);
    in_scale   = 18'(k);
    cur_tag    = tag;
    tick(1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    in_nbr_cnt = '0; in_past = 0; in_fut = 0; in_obs = '0; in_amp = '0; in_scale = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    check(out_valid === 1'b0, "R6", int'(out_valid), 0);
    check(in_ready === 1'b1, "R6", int'(in_ready), 1);
    @(negedge clk);

    // Directed corners, no backpressure.
    send(0, 0, 0, 0, 20, 16384, "R8");       // s=0, o=0 -> 0
    send(8, 1, 1, 0, 20, 16384, "R8");       // um1=-200, o=0 -> 1
    send(8, 0, 0, 0, 20, 16384, "R8");       // um1=-120 vs -100 -> 1
    send(0, 1, 1, 255, 20, 65536, "R1");     // um1=120, large obs -> 1
    send(4, 0, 0, 11, 20, 65536, "R2");      // tie 40 == 40 -> 0
    send(4, 0, 0, 12, 20, 65536, "R2");      // 40 < 80 -> 1
    send(12, 0, 0, 0, 20, 16384, "R3");      // saturated to 8 -> 1
    send(15, 1, 1, 0, 20, 16384, "R3");      // saturated to 8 -> 1
    send(5, 0, 0, 200, 255, 0, "R4");        // scale 0, um1=0 -> 0
    send(6, 0, 0, 200, 255, 0, "R4");        // scale 0, um1=-40 -> 1
    send(3, 1, 0, 30, 20, 4096, "R1");
    send(2, 0, 1, 90, 40, 8192, "R1");
    for (int i = 0; i < 200; i++) begin
      send(int'($urandom_range(0, 8)), int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
           int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
           int'($urandom_range(0, 262143)), "R2");
    end

    // Random traffic with backpressure.
    for (int i = 0; i < 3000; i++) begin
      in_valid   = ($urandom_range(0, 3) != 0);
      out_ready  = ($urandom_range(0, 2) != 0);
      in_nbr_cnt = 4'($urandom_range(0, 15));
      in_past    = 1'($urandom_range(0, 1));
      in_fut     = 1'($urandom_range(0, 1));
      in_obs     = 8'($urandom_range(0, 255));
      in_amp     = 8'($urandom_range(0, 255));
      in_scale   = 18'($urandom_range(0, 262143));
      cur_tag    = "R7";
      tick(1'b0);
    end

    // Drain.
    in_valid  = 1'b0;
    out_ready = 1'b1;
    for (int i = 0; i < 8; i++) tick(1'b0);
    check(q.size() == 0, "R5", q.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule